// File: doc/BRIEF.md
# Three-Bus Register ALU Datapath

This block is a small register datapath with four general registers, two read buses and one write-back bus. Each instruction names one register for read bus A and one for read bus B. Each name goes through its own one-hot decoder, which enables that register onto its bus. The two buses feed the operand inputs of an ALU. The ALU output travels on bus C back to the data inputs of every register.

The write-back field of the instruction is not an encoded register number. It is a per-register load mask, so one result can be copied into any subset of the registers in a single transfer. A common write strobe gates every load.

Registers leave reset holding small distinct seed values, because the datapath has no external data input. Software-visible state is only the register file itself and the combinational ALU result on bus C.

Top module: `tribus_datapath`

## Requirements
- R1: While reset is active, and after it is released, register i holds the value i+1 until the first write. With the defaults, `regs_flat` reads 32'h04030201, and register i sits at bits [8*i+7:8*i].
- R2: Instruction bits [1:0] select the register driven onto bus A and bits [3:2] select the register driven onto bus B. `alu_res` follows the selected registers and the function select combinationally, within the same cycle.
- R3: Function select 2'b00 gives A + B, wrapped modulo 2^DATA_W.
- R4: Function select 2'b01 gives A - B, wrapped modulo 2^DATA_W.
- R5: Function select 2'b10 gives A AND B, and 2'b11 gives A OR B, bit by bit.
- R6: When both bus selects name the same register, both operands equal that register's value.
- R7: On a rising clock edge with `wr_stb` high, every register whose mask bit (instruction bit 4+i for register i) is 1 loads `alu_res`. Registers whose mask bit is 0 keep their value. Several registers may load the same result at one edge.
- R8: On a rising clock edge with `wr_stb` low, no register changes, whatever the mask.
- R9: With an all-zero mask and `wr_stb` high, no register changes, but `alu_res` still shows the operation's result.
- R10: An instruction that writes one of its own source registers computes with the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 2*SEL_W+NUM_REGS (8) | {load mask, bus B select, bus A select} |
| alu_fn | input | 2 | ALU function: 00 add, 01 sub, 10 and, 11 or |
| wr_stb | input | 1 | Write strobe that gates all register loads |
| regs_flat | output | NUM_REGS*DATA_W (32) | All register contents, register i at slice i |
| alu_res | output | DATA_W (8) | ALU result as carried on bus C |

## Verification
A reference model of the four registers predicts bus C and the register file for every transfer. The directed transfers come first:
- Subtraction that underflows and addition that overflows, which separate a wrapping ALU from one that saturates or truncates badly.
- A sweep of all sixteen source pairs with a zero mask, which separates the two decoders from each other and from the write path.
- Full masks, single-bit masks and transfers with the strobe low, which expose loads that ignore the mask or the strobe.
- A transfer that reads and writes the same register, which shows whether the operands are sampled before the edge.

Several hundred random instructions follow, many of them writing to several destinations at once.

// File: rtl/tbdp_pkg.sv
package tbdp_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;

endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rb_decoder.sv
module rb_decoder #(
  parameter int SEL_W   = 2,
  parameter int NUM_OUT = 4
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] onehot
);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    assign onehot[g] = (sel == SEL_W'(g));
  end

endmodule

// File: rtl/rb_bus_drive.sv
module rb_bus_drive #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic [NUM_REGS-1:0]        drv_en,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          bus
);

  // Each register drives its gated value. An OR across the gated values
  // stands in for shared wires with only one driver enabled.
  logic [DATA_W-1:0] gated [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_drv
    assign gated[g] = regs_flat[g*DATA_W +: DATA_W] & {DATA_W{drv_en[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NUM_REGS; i++) bus = bus | gated[i];
  end

endmodule

// File: rtl/rb_alu.sv
module rb_alu
  import tbdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        fn,
  output logic [DATA_W-1:0] res
);

  alu_fn_e fn_e;
  assign fn_e = alu_fn_e'(fn);

  always_comb begin
    unique case (fn_e)
      FN_ADD:  res = op_a + op_b;
      FN_SUB:  res = op_a - op_b;
      FN_AND:  res = op_a & op_b;
      FN_OR:   res = op_a | op_b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/rb_regfile.sv
module rb_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int RST_BASE = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [NUM_REGS-1:0]        ld_mask,
  input  logic [DATA_W-1:0]          bus_c,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] SEED = DATA_W'(RST_BASE + g);

    logic              ld_en;
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] val_d;

    assign ld_en = wr_stb & ld_mask[g];

    always_comb begin
      val_d = val_q;
      if (ld_en) val_d = bus_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= SEED;
      else        val_q <= val_d;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int RST_BASE = 1,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int INSTR_W = 2*SEL_W + NUM_REGS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [INSTR_W-1:0]         instr,
  input  logic [1:0]                 alu_fn,
  input  logic                       wr_stb,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          alu_res
);

  logic                rst_n_q;
  logic [SEL_W-1:0]    sel_a;
  logic [SEL_W-1:0]    sel_b;
  logic [NUM_REGS-1:0] ld_mask;
  logic [NUM_REGS-1:0] en_a;
  logic [NUM_REGS-1:0] en_b;
  logic [DATA_W-1:0]   bus_a;
  logic [DATA_W-1:0]   bus_b;
  logic [DATA_W-1:0]   bus_c;

  assign sel_a   = instr[SEL_W-1:0];
  assign sel_b   = instr[2*SEL_W-1:SEL_W];
  assign ld_mask = instr[INSTR_W-1:2*SEL_W];

  rb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_q)
  );

  rb_decoder #(.SEL_W(SEL_W), .NUM_OUT(NUM_REGS)) u_dec_a (
    .sel(sel_a), .onehot(en_a)
  );

  rb_decoder #(.SEL_W(SEL_W), .NUM_OUT(NUM_REGS)) u_dec_b (
    .sel(sel_b), .onehot(en_b)
  );

  rb_bus_drive #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bus_a (
    .drv_en(en_a), .regs_flat(regs_flat), .bus(bus_a)
  );

  rb_bus_drive #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bus_b (
    .drv_en(en_b), .regs_flat(regs_flat), .bus(bus_b)
  );

  rb_alu #(.DATA_W(DATA_W)) u_alu (
    .op_a(bus_a), .op_b(bus_b), .fn(alu_fn), .res(bus_c)
  );

  rb_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_rf (
    .clk(clk), .rst_n(rst_n_q), .wr_stb(wr_stb), .ld_mask(ld_mask),
    .bus_c(bus_c), .regs_flat(regs_flat)
  );

  assign alu_res = bus_c;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int INSTR_W = 2*SEL_W + NUM_REGS
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic [INSTR_W-1:0]         instr,
  input logic [1:0]                 alu_fn,
  input logic                       wr_stb,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input logic [DATA_W-1:0]          alu_res
);

  logic [DATA_W-1:0] ref_a;
  logic [DATA_W-1:0] ref_b;

  always_comb begin
    ref_a = '0;
    ref_b = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (instr[SEL_W-1:0] == SEL_W'(i))         ref_a = regs_flat[i*DATA_W +: DATA_W];
      if (instr[2*SEL_W-1:SEL_W] == SEL_W'(i))   ref_b = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  p_add_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    alu_fn == 2'b00 |-> alu_res == DATA_W'(ref_a + ref_b));

  p_sub_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    alu_fn == 2'b01 |-> alu_res == DATA_W'(ref_a - ref_b));

  p_logic_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    alu_fn[1] |-> alu_res == (alu_fn[0] ? (ref_a | ref_b) : (ref_a & ref_b)));

  p_same_src_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (instr[SEL_W-1:0] == instr[2*SEL_W-1:SEL_W] && alu_fn == 2'b10) |-> alu_res == ref_a);

  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_stb |=> $stable(regs_flat));

  p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    instr[INSTR_W-1:2*SEL_W] == '0 |=> $stable(regs_flat));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_ok)
      (wr_stb && instr[2*SEL_W+g]) |=> regs_flat[g*DATA_W +: DATA_W] == $past(alu_res));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ok)
      !(wr_stb && instr[2*SEL_W+g]) |=> $stable(regs_flat[g*DATA_W +: DATA_W]));
  end

endmodule

bind tribus_datapath rb_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_ok(rst_n_q), .instr(instr), .alu_fn(alu_fn),
  .wr_stb(wr_stb), .regs_flat(regs_flat), .alu_res(alu_res)
);

// File: tb/test_tribus_datapath.sv
`timescale 1ns/1ps
module test_tribus_datapath;

  localparam int W  = 8;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    instr;
  logic [1:0]    alu_fn;
  logic          wr_stb;
  logic [31:0]   regs_flat;
  logic [W-1:0]  alu_res;

  always #2.5 clk = ~clk;

  tribus_datapath #(.DATA_W(W), .NUM_REGS(NR), .RST_BASE(1)) i_tribus_datapath (
    .clk(clk), .rst_n(rst_n), .instr(instr), .alu_fn(alu_fn),
    .wr_stb(wr_stb), .regs_flat(regs_flat), .alu_res(alu_res)
  );

  typedef struct {
    string       tag;
    logic [31:0] exp_alu;
    logic [31:0] exp_regs;
  } item_t;

  item_t       sb_q[$];
  logic [W-1:0] mdl [NR];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_mdl();
    logic [31:0] v;
    for (int i = 0; i < NR; i++) v[i*W +: W] = mdl[i];
    return v;
  endfunction

  // Driver: applies one instruction for one cycle and pushes the prediction.
  task automatic issue(string tag, int sa, int sb, logic [3:0] mask,
                       logic [1:0] fn, logic stb);
    logic [W-1:0] a, b, r;
    item_t it;
    @(negedge clk);
    instr  = {mask, 2'(sb), 2'(sa)};
    alu_fn = fn;
    wr_stb = stb;
    a = mdl[sa];
    b = mdl[sb];
    case (fn)
      2'b00:   r = a + b;
      2'b01:   r = a - b;
      2'b10:   r = a & b;
      default: r = a | b;
    endcase
    if (stb) for (int i = 0; i < NR; i++) if (mask[i]) mdl[i] = r;
    it.tag = tag;
    it.exp_alu = {24'd0, r};
    it.exp_regs = pack_mdl();
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      instr  = 8'h00;
    end
  endtask

  // Monitor: bus C is checked in the cycle of issue, registers one cycle later.
  initial begin : monitor
    item_t       it;
    bit          pend = 1'b0;
    logic [31:0] pend_regs;
    string       pend_tag;
    forever begin
      @(negedge clk);
      #1;
      if (pend) begin
        chk({pend_tag, " regs"}, regs_flat, pend_regs);
        pend = 1'b0;
      end
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk({it.tag, " bus C"}, {24'd0, alu_res}, it.exp_alu);
        pend      = 1'b1;
        pend_regs = it.exp_regs;
        pend_tag  = it.tag;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    rst_n  = 1'b0;
    instr  = 8'h00;
    alu_fn = 2'b00;
    wr_stb = 1'b0;
    for (int i = 0; i < NR; i++) mdl[i] = W'(i + 1);
    repeat (3) @(negedge clk);
    chk("R1 during reset", regs_flat, 32'h04030201);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 after release", regs_flat, 32'h04030201);

    issue("R3 add r1+r2 into r0", 1, 2, 4'b0001, 2'b00, 1'b1);
    issue("R4 sub r0-r3 into r1", 0, 3, 4'b0010, 2'b01, 1'b1);
    issue("R4 underflow r1-r3 into r2", 1, 3, 4'b0100, 2'b01, 1'b1);
    issue("R3 overflow r2+r2 into r3", 2, 2, 4'b1000, 2'b00, 1'b1);
    issue("R5 and r2&r0 into r1", 2, 0, 4'b0010, 2'b10, 1'b1);
    issue("R5 or r3|r0 into r0", 3, 0, 4'b0001, 2'b11, 1'b1);
    issue("R6 same source and", 3, 3, 4'b0000, 2'b10, 1'b1);
    issue("R6 same source add", 1, 1, 4'b0100, 2'b00, 1'b1);
    issue("R8 strobe low full mask", 0, 1, 4'b1111, 2'b00, 1'b0);
    issue("R9 empty mask", 2, 3, 4'b0000, 2'b01, 1'b1);
    issue("R7 broadcast to all", 0, 2, 4'b1111, 2'b00, 1'b1);
    issue("R7 two destinations", 1, 3, 4'b0101, 2'b01, 1'b1);
    issue("R10 r0 doubled into r0", 0, 0, 4'b0001, 2'b00, 1'b1);
    issue("R10 r3 minus r1 into r3", 3, 1, 4'b1000, 2'b01, 1'b1);
    issue("R7 seed r1", 0, 2, 4'b0010, 2'b11, 1'b1);
    for (int sa = 0; sa < NR; sa++)
      for (int sb = 0; sb < NR; sb++)
        issue("R2 source sweep", sa, sb, 4'b0000, 2'b01, 1'b1);
    for (int n = 0; n < 400; n++)
      issue("R7 random", int'($urandom_range(3)), int'($urandom_range(3)),
            4'($urandom), 2'($urandom), 1'($urandom_range(7) != 0));
    idle(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule